// File: doc/BRIEF.md
# Power-Management Event Aggregator

This block keeps the power-management event state of a chipset function: a fixed-function event status/enable register pair (the "primary" events) and a general-purpose event window whose lower half is status and upper half is enable. Event sources raise status bits through one-cycle strobes. Software clears a status bit by writing a one to it and programs the enables as plain read/write bytes. The block combines the enabled status of a fixed set of sources into a level-sensitive system-control interrupt (SCI).

Software reaches all registers through one byte-lane access port. An access of one to four bytes is broken into independent byte operations, with the lowest address taking the least significant byte. A separate power-management command port takes a command byte. One value turns the ACPI-mode control bit on, and another turns it off. Any command write can also raise a one-cycle SMI pulse when a configuration input allows it. A timer-arm output tells an external free-running timer when an overflow interrupt is wanted.

Top module: `sci_event_agg`

## Requirements
- R1: After reset every status and enable byte reads zero, and `sci_o`, `smi_o`, `acpi_mode_o` and `tmr_arm_o` are low.
- R2: A one on `pm1_set[i]` sets primary status bit i. Writing 1 to a status bit clears it, and writing 0 leaves it as it was. A set and a clear of the same bit in the same cycle leave the bit set.
- R3: `gpe_set[i]` sets general-purpose status bit i with the same write-one-to-clear and set-wins rules as R2.
- R4: Enable bytes store the written value and read it back, and they change only when written.
- R5: `sci_o` is high in the cycle after the stored state has (primary status AND primary enable) with any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (real-time clock) set.
- R6: `sci_o` is also high in the cycle after the stored state has (general-purpose status AND enable) with bit 1 (PCI hotplug) or bit 2 (CPU hotplug) set. No other bit of either register asserts SCI.
- R7: The byte map is: offsets 0–1 primary status, 2–3 primary enable, 4–5 general-purpose status, 6–7 general-purpose enable. A write with `acc_len` n touches offsets `acc_addr`..`acc_addr`+n−1, using byte k of `acc_wdata` for offset `acc_addr`+k. A length above 4 counts as 4, a length of 0 touches nothing, and offsets past 7 are dropped.
- R8: `acc_rdata` byte k returns the byte at offset `acc_addr`+k when k < n and the offset is inside the window. All other bytes of `acc_rdata` are zero.
- R9: A command write of 0xF1 sets `acpi_mode_o`, and 0xF0 clears it, one cycle later. Any other value leaves it unchanged.
- R10: `smi_o` is high for the cycle after each command write made while `smi_on_apm` is high. It is low at every other time.
- R11: `tmr_arm_o` is high exactly when primary enable bit 0 is set and primary status bit 0 is clear, following the stored registers without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_addr | input | 3 | Start byte offset of the access |
| acc_len | input | 3 | Access length in bytes |
| acc_wr | input | 1 | Write strobe for the access |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_rdata | output | 32 | Read data, little-endian lanes |
| pm1_set | input | 16 | Primary event set strobes |
| gpe_set | input | 16 | General-purpose event set strobes |
| apm_wr | input | 1 | Command byte write strobe |
| apm_cmd | input | 8 | Command byte |
| smi_on_apm | input | 1 | Configuration: command writes raise SMI |
| sci_o | output | 1 | Level-sensitive SCI |
| smi_o | output | 1 | One-cycle SMI pulse |
| acpi_mode_o | output | 1 | ACPI-mode control bit |
| tmr_arm_o | output | 1 | Timer overflow interrupt wanted |

## Verification
The bench builds the block with its default sizes: two primary bytes and a four-byte general-purpose window, so the whole map is eight offsets. With only eight offsets, a four-byte access that starts at offsets 5 to 7 runs off the end of the window, and lengths of 0 and above 4 reach the clipping rule. Every bit of both status registers can be driven directly, so the bench can confirm that each SCI source works and that every other source bit does not assert SCI.

// File: rtl/sci_agg_pkg.sv
package sci_agg_pkg;
    // primary event bit positions that may raise SCI
    localparam int TMR_BIT    = 0;
    localparam int GLOCK_BIT  = 5;
    localparam int PWRBTN_BIT = 8;
    localparam int RTC_BIT    = 10;
    // general-purpose event bits that may raise SCI
    localparam int PCIHP_BIT  = 1;
    localparam int CPUHP_BIT  = 2;
    // command byte values
    localparam logic [7:0] CMD_MODE_ON  = 8'hF1;
    localparam logic [7:0] CMD_MODE_OFF = 8'hF0;
    // widest access in bytes
    localparam int MAX_LANES = 4;
endpackage

// File: rtl/sci_lane_split.sv
module sci_lane_split #(
    parameter int WIN    = 8,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [2:0]         len_i,
    input  logic               wr_i,
    input  logic [31:0]        wdata_i,
    input  logic [WIN*8-1:0]   regs_i,
    output logic [WIN-1:0]     byte_we_o,
    output logic [WIN*8-1:0]   byte_wd_o,
    output logic [31:0]        rdata_o
);
    import sci_agg_pkg::*;

    int n_lanes;
    int base;

    always_comb begin
        n_lanes   = (int'(len_i) > MAX_LANES) ? MAX_LANES : int'(len_i);
        base      = int'(addr_i);
        byte_we_o = '0;
        byte_wd_o = '0;
        rdata_o   = '0;
        for (int k = 0; k < MAX_LANES; k++) begin
            for (int j = 0; j < WIN; j++) begin
                if (k < n_lanes && j == base + k) begin
                    byte_we_o[j]       = wr_i;
                    byte_wd_o[j*8 +: 8] = wdata_i[k*8 +: 8];
                    rdata_o[k*8 +: 8]   = regs_i[j*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/sci_evt_bank.sv
module sci_evt_bank #(
    parameter int NBYTES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NBYTES-1:0]   sts_we_i,
    input  logic [NBYTES*8-1:0] sts_wd_i,
    input  logic [NBYTES-1:0]   en_we_i,
    input  logic [NBYTES*8-1:0] en_wd_i,
    input  logic [NBYTES*8-1:0] set_i,
    output logic [NBYTES*8-1:0] sts_o,
    output logic [NBYTES*8-1:0] en_o
);
    localparam int W = NBYTES * 8;

    typedef struct packed {
        logic [W-1:0] sts;
        logic [W-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        bank_d   = bank_q;
        clr_mask = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (sts_we_i[b]) clr_mask[b*8 +: 8] = sts_wd_i[b*8 +: 8];
            if (en_we_i[b])  bank_d.en[b*8 +: 8] = en_wd_i[b*8 +: 8];
        end
        // a set in the same cycle as a clear wins
        bank_d.sts = (bank_q.sts & ~clr_mask) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign sts_o = bank_q.sts;
    assign en_o  = bank_q.en;

    p_set_sticks_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));

    p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we_i == '0) |=> $stable(en_o));
endmodule

// File: rtl/sci_apm_ctl.sv
module sci_apm_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apm_wr_i,
    input  logic [7:0] apm_cmd_i,
    input  logic       smi_on_apm_i,
    output logic       acpi_mode_o,
    output logic       smi_o
);
    import sci_agg_pkg::*;

    typedef struct packed {
        logic mode;
        logic smi;
    } apm_t;

    apm_t apm_d, apm_q;

    always_comb begin
        apm_d     = apm_q;
        apm_d.smi = apm_wr_i && smi_on_apm_i;
        if (apm_wr_i) begin
            if (apm_cmd_i == CMD_MODE_ON)       apm_d.mode = 1'b1;
            else if (apm_cmd_i == CMD_MODE_OFF) apm_d.mode = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) apm_q <= '0;
        else        apm_q <= apm_d;
    end

    assign acpi_mode_o = apm_q.mode;
    assign smi_o       = apm_q.smi;

    p_mode_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!apm_wr_i || (apm_cmd_i != CMD_MODE_ON && apm_cmd_i != CMD_MODE_OFF))
        |=> $stable(acpi_mode_o));

    p_smi_needs_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(apm_wr_i && smi_on_apm_i) |=> !smi_o);
endmodule

// File: rtl/sci_event_agg.sv
module sci_event_agg #(
    parameter int PM1_BYTES = 2,
    parameter int GPE_BYTES = 4,
    localparam int PM1_W    = PM1_BYTES * 8,
    localparam int GPE_HALF = GPE_BYTES / 2,
    localparam int GPE_W    = GPE_HALF * 8,
    localparam int WIN      = 2 * PM1_BYTES + GPE_BYTES,
    localparam int ADDR_W   = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_len,
    input  logic              acc_wr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic [PM1_W-1:0]  pm1_set,
    input  logic [GPE_W-1:0]  gpe_set,
    input  logic              apm_wr,
    input  logic [7:0]        apm_cmd,
    input  logic              smi_on_apm,
    output logic              sci_o,
    output logic              smi_o,
    output logic              acpi_mode_o,
    output logic              tmr_arm_o
);
    import sci_agg_pkg::*;

    localparam int PM1_EN_LO = PM1_BYTES;
    localparam int GPE_ST_LO = 2 * PM1_BYTES;
    localparam int GPE_EN_LO = GPE_ST_LO + GPE_HALF;

    localparam logic [PM1_W-1:0] PM1_SCI_MASK =
        (PM1_W'(1) << TMR_BIT) | (PM1_W'(1) << GLOCK_BIT) |
        (PM1_W'(1) << PWRBTN_BIT) | (PM1_W'(1) << RTC_BIT);
    localparam logic [GPE_W-1:0] GPE_SCI_MASK =
        (GPE_W'(1) << PCIHP_BIT) | (GPE_W'(1) << CPUHP_BIT);

    typedef struct packed {
        logic sci;
    } top_t;

    top_t top_d, top_q;

    logic [PM1_W-1:0] pm1_sts, pm1_en;
    logic [GPE_W-1:0] gpe_sts, gpe_en;
    logic [WIN*8-1:0] reg_flat;
    logic [WIN-1:0]   byte_we;
    logic [WIN*8-1:0] byte_wd;

    assign reg_flat = {gpe_en, gpe_sts, pm1_en, pm1_sts};

    sci_lane_split #(.WIN(WIN), .ADDR_W(ADDR_W)) u_split (
        .addr_i    (acc_addr),
        .len_i     (acc_len),
        .wr_i      (acc_wr),
        .wdata_i   (acc_wdata),
        .regs_i    (reg_flat),
        .byte_we_o (byte_we),
        .byte_wd_o (byte_wd),
        .rdata_o   (acc_rdata)
    );

    sci_evt_bank #(.NBYTES(PM1_BYTES)) u_pm1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts_we_i (byte_we[PM1_BYTES-1:0]),
        .sts_wd_i (byte_wd[PM1_W-1:0]),
        .en_we_i  (byte_we[GPE_ST_LO-1:PM1_EN_LO]),
        .en_wd_i  (byte_wd[GPE_ST_LO*8-1:PM1_EN_LO*8]),
        .set_i    (pm1_set),
        .sts_o    (pm1_sts),
        .en_o     (pm1_en)
    );

    sci_evt_bank #(.NBYTES(GPE_HALF)) u_gpe (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts_we_i (byte_we[GPE_EN_LO-1:GPE_ST_LO]),
        .sts_wd_i (byte_wd[GPE_EN_LO*8-1:GPE_ST_LO*8]),
        .en_we_i  (byte_we[WIN-1:GPE_EN_LO]),
        .en_wd_i  (byte_wd[WIN*8-1:GPE_EN_LO*8]),
        .set_i    (gpe_set),
        .sts_o    (gpe_sts),
        .en_o     (gpe_en)
    );

    sci_apm_ctl u_apm (
        .clk          (clk),
        .rst_n        (rst_n),
        .apm_wr_i     (apm_wr),
        .apm_cmd_i    (apm_cmd),
        .smi_on_apm_i (smi_on_apm),
        .acpi_mode_o  (acpi_mode_o),
        .smi_o        (smi_o)
    );

    always_comb begin
        top_d     = top_q;
        top_d.sci = (|(pm1_sts & pm1_en & PM1_SCI_MASK)) |
                    (|(gpe_sts & gpe_en & GPE_SCI_MASK));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign sci_o     = top_q.sci;
    assign tmr_arm_o = pm1_en[TMR_BIT] & ~pm1_sts[TMR_BIT];

    p_rise_needs_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci_o) |-> $past((|(pm1_sts & pm1_en)) | (|(gpe_sts & gpe_en))));

    p_no_enable_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pm1_en == '0 && gpe_en == '0) |=> !sci_o);

    p_len0_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_len == 3'd0 && pm1_set == '0 && gpe_set == '0) |=> $stable(reg_flat));

    p_arm_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_arm_o |-> pm1_en[TMR_BIT]);
endmodule

// File: tb/tb_sci_event_agg.sv
`timescale 1ns/1ps
module tb_sci_event_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [2:0]  acc_len = '0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [15:0] pm1_set = '0;
    logic [15:0] gpe_set = '0;
    logic        apm_wr = 1'b0;
    logic [7:0]  apm_cmd = '0;
    logic        smi_on_apm = 1'b0;
    logic        sci_o, smi_o, acpi_mode_o, tmr_arm_o;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [7:0] m_reg [8];
    logic m_mode, m_smi, m_sci;

    always #4 clk = ~clk;

    sci_event_agg dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_len(acc_len),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .pm1_set(pm1_set), .gpe_set(gpe_set), .apm_wr(apm_wr), .apm_cmd(apm_cmd),
        .smi_on_apm(smi_on_apm), .sci_o(sci_o), .smi_o(smi_o),
        .acpi_mode_o(acpi_mode_o), .tmr_arm_o(tmr_arm_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read();
        logic [31:0] r = '0;
        int n = (acc_len > 4) ? 4 : int'(acc_len);
        for (int k = 0; k < n; k++)
            if (int'(acc_addr) + k < 8) r[k*8 +: 8] = m_reg[int'(acc_addr) + k];
        return r;
    endfunction

    function automatic logic m_pending();
        logic [15:0] ps = {m_reg[1], m_reg[0]}, pe = {m_reg[3], m_reg[2]};
        logic [15:0] gs = {m_reg[5], m_reg[4]}, ge = {m_reg[7], m_reg[6]};
        return ((ps & pe & 16'h0521) != 0) || ((gs & ge & 16'h0006) != 0);
    endfunction

    task automatic m_update();
        int n = (acc_len > 4) ? 4 : int'(acc_len);
        m_sci = m_pending();
        if (acc_wr)
            for (int k = 0; k < n; k++) begin
                int idx = int'(acc_addr) + k;
                if (idx < 8) begin
                    if (idx == 0 || idx == 1 || idx == 4 || idx == 5)
                        m_reg[idx] = m_reg[idx] & ~acc_wdata[k*8 +: 8];
                    else
                        m_reg[idx] = acc_wdata[k*8 +: 8];
                end
            end
        m_reg[0] |= pm1_set[7:0];
        m_reg[1] |= pm1_set[15:8];
        m_reg[4] |= gpe_set[7:0];
        m_reg[5] |= gpe_set[15:8];
        m_smi = apm_wr && smi_on_apm;
        if (apm_wr && apm_cmd == 8'hF1) m_mode = 1'b1;
        else if (apm_wr && apm_cmd == 8'hF0) m_mode = 1'b0;
    endtask

    // one clock: read check, edge, registered-output checks
    task automatic tick();
        #1;
        chk(cur_req, "rdata", acc_rdata, m_read());
        @(posedge clk);
        m_update();
        @(negedge clk);
        chk("R5/R6", "sci", 32'(sci_o), 32'(m_sci));
        chk("R10", "smi", 32'(smi_o), 32'(m_smi));
        chk("R9", "mode", 32'(acpi_mode_o), 32'(m_mode));
        chk("R11", "tmr_arm", 32'(tmr_arm_o), 32'(m_reg[2][0] & ~m_reg[0][0]));
    endtask

    task automatic idle();
        acc_wr = 0; acc_len = 0; pm1_set = 0; gpe_set = 0; apm_wr = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [2:0] l, input logic [31:0] d);
        idle(); acc_addr = a; acc_len = l; acc_wr = 1; acc_wdata = d;
        tick(); idle();
    endtask

    task automatic rd(input logic [2:0] a, input logic [2:0] l);
        idle(); acc_addr = a; acc_len = l; tick();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_mode = 0; m_smi = 0; m_sci = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        acc_addr = 0; acc_len = 4; #1;
        chk("R1", "rdata lo", acc_rdata, 32'h0);
        acc_addr = 4; #1;
        chk("R1", "rdata hi", acc_rdata, 32'h0);
        chk("R1", "outputs", {28'h0, sci_o, smi_o, acpi_mode_o, tmr_arm_o}, 32'h0);
        @(negedge clk); rst_n = 1;
        rd(0, 4); rd(4, 4);

        // R4: primary enables for all SCI sources
        cur_req = "R4";
        wr(2, 2, 32'h0000_0521); rd(2, 2); rd(0, 4);
        // R5: power button raises SCI
        cur_req = "R5";
        idle(); pm1_set = 16'h0100; tick(); idle(); tick(); tick();
        // R2: write zero keeps, write one clears
        cur_req = "R2";
        wr(0, 2, 32'h0000_0000); rd(0, 2);
        wr(0, 2, 32'h0000_0100); rd(0, 2); tick();
        // R11 / R5: timer status disarms and raises SCI
        cur_req = "R5";
        idle(); pm1_set = 16'h0001; tick(); idle(); tick();
        wr(0, 1, 32'h0000_00FF); tick();
        // R6: unmasked primary bit does not raise SCI
        cur_req = "R6";
        wr(2, 2, 32'h0000_FFFF); idle(); pm1_set = 16'h0008; tick(); idle(); tick();
        wr(0, 2, 32'h0000_FFFF); wr(2, 2, 32'h0000_0000);
        // R3/R6: general-purpose bits
        cur_req = "R3";
        wr(6, 2, 32'h0000_FFFF);
        idle(); gpe_set = 16'h0001; tick(); idle(); tick(); tick();
        idle(); gpe_set = 16'h0200; tick(); idle(); tick();
        idle(); gpe_set = 16'h0002; tick(); idle(); tick();
        wr(4, 1, 32'h0000_0002); tick();
        idle(); gpe_set = 16'h0004; tick(); idle(); tick();
        // R3: set wins over simultaneous clear
        idle(); acc_addr = 4; acc_len = 1; acc_wr = 1; acc_wdata = 32'hFF; gpe_set = 16'h0004;
        tick(); idle(); rd(4, 2);
        wr(4, 2, 32'hFFFF); tick();
        // R7: window end clipping, oversized length, zero length
        cur_req = "R7";
        wr(5, 4, 32'hA1B2_C3D4); rd(4, 4);
        wr(2, 7, 32'h1122_3344); rd(0, 4); rd(4, 4);
        wr(6, 0, 32'hFFFF_FFFF); rd(4, 4);
        // R8: partial reads
        cur_req = "R8";
        rd(3, 2); rd(7, 4); rd(1, 0); rd(6, 5);
        // R9/R10: command port
        cur_req = "R9";
        idle(); apm_wr = 1; apm_cmd = 8'hF1; tick(); idle(); tick();
        apm_wr = 1; apm_cmd = 8'h55; tick(); idle(); tick();
        apm_wr = 1; apm_cmd = 8'hF0; tick(); idle(); tick();
        cur_req = "R10";
        smi_on_apm = 1; apm_wr = 1; apm_cmd = 8'h00; tick();
        apm_wr = 1; apm_cmd = 8'hF1; tick(); idle(); tick();
        smi_on_apm = 0; apm_wr = 1; tick(); idle(); tick();
        // mixed random traffic against the model
        cur_req = "R7/R8";
        for (int i = 0; i < 400; i++) begin
            acc_addr = 3'($urandom); acc_len = 3'($urandom); acc_wr = 1'($urandom);
            acc_wdata = $urandom;
            pm1_set = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
            gpe_set = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
            apm_wr = ($urandom % 5 == 0);
            apm_cmd = ($urandom % 2) ? 8'hF0 + 8'($urandom % 2) : 8'($urandom);
            smi_on_apm = 1'($urandom);
            tick();
        end
        idle(); tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule